// File: doc/BRIEF.md
# Receiver-activity power-down controller

This block sits beside the line receivers of a multi-channel serial transceiver. It decides when the line drivers and their supply generator are powered. Each receiver channel supplies one activity flag, which is high while a remote transmitter holds the line away from its pulled-down idle level. Two control pins choose the mode. An active-low shutdown pin has top priority. An override pin keeps the drivers on whatever the line shows. With neither pin in force, the block runs in automatic mode and follows line activity.

In automatic mode the block wakes when any channel shows activity. It first enables the supply generator and waits a settling interval before it enables the drivers. Once every channel has gone quiet, an inactivity timer runs. If the lines stay quiet for the whole delay, the block powers down again. Both intervals are parameters counted in clock cycles. At 100 MHz the defaults come to about 20 µs for the inactivity delay and 200 µs for the settling time. A status flag reports line presence. Separate enables control the normal receiver outputs and one monitor output, which stays on in every power state.

The activity flags pass through two-flop synchronisers inside the block. The control pins are taken as already synchronous to the clock.

Top module: `rx_idle_pwrdn`

## Requirements
- R1: While shdn_n is low, drv_en and pump_en are low in the same cycle, whatever force_on and the activity inputs show, and the block stays powered down.
- R2: In automatic mode (shdn_n high, force_on low), the block wakes when any synchronised activity flag is high. It stays off while all flags are low. Once powered, it turns drv_en and pump_en off after IDLE_CYCLES consecutive cycles spent counting with every flag low.
- R3: With shdn_n high and force_on high, the block wakes with no line activity and keeps drv_en high for as long as both pins stay high.
- R4: Activity seen during the inactivity count returns the block to full-on and clears the count. The next power-down then needs a full IDLE_CYCLES of quiet, counted afresh.
- R5: status is a register that is high exactly when, on the previous clock edge, shdn_n was high and at least one synchronised activity flag was high. Under the override with quiet lines, it is low.
- R6: On wake, pump_en rises one edge after the wake condition is seen. drv_en rises SETTLE_CYCLES edges after that. Shutdown during settling aborts the wake, and the next wake waits the full SETTLE_CYCLES again.
- R7: Every bit of rx_out_en equals the inverse of rx_oe_n in every power state. mon_en is high from the first clock edge after reset, including during shutdown.
- R8: With force_on and shdn_n driven from one signal, a high level gives drivers on after settling with quiet lines, and a low level gives drivers and supply off at once.
- R9: An activity input change reaches the control logic after two flop stages. From a change before edge 1, the first power-state change happens at edge 3.
- R10: While reset is asserted, status, drv_en, pump_en and mon_en are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| act_raw | input | NUM_CH | Per-channel line activity flags, asynchronous |
| shdn_n | input | 1 | Active-low shutdown, top priority |
| force_on | input | 1 | Override: keep drivers on, bypass automatic mode |
| rx_oe_n | input | 1 | High puts the normal receiver outputs in high impedance |
| status | output | 1 | Line presence flag, low in shutdown |
| drv_en | output | 1 | Line driver enable |
| pump_en | output | 1 | Supply generator enable |
| rx_out_en | output | NUM_CH | Output enables of the normal receivers |
| mon_en | output | 1 | Output enable of the always-on monitor receiver |

## Verification
The bench builds the block with three channels, a six-cycle inactivity delay and a four-cycle settling time. With these short windows it can time every edge of wake-up, settling, countdown and restart. It can also sweep all eight activity patterns against every combination of the shutdown, override and receiver-enable pins, resetting the block each time. Directed sequences cover the cases a sweep from reset does not reach: activity returning in mid-countdown, shutdown during settling, and the two control pins tied together.

// File: rtl/pdc_pkg.sv
package pdc_pkg;
  typedef enum logic [1:0] {
    PS_OFF  = 2'd0,
    PS_WAKE = 2'd1,
    PS_ON   = 2'd2,
    PS_IDLE = 2'd3
  } pwr_state_t;
endpackage

// File: rtl/pdc_act_sync.sv
module pdc_act_sync #(
  parameter int NUM_CH = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] act_raw,
  output logic [NUM_CH-1:0] act_s
);
  logic [NUM_CH-1:0] meta_q;
  logic [NUM_CH-1:0] sync_q;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q[i] <= 1'b0;
        sync_q[i] <= 1'b0;
      end else begin
        meta_q[i] <= act_raw[i];
        sync_q[i] <= meta_q[i];
      end
    end
  end

  assign act_s = sync_q;
endmodule

// File: rtl/pdc_tick_timer.sv
module pdc_tick_timer #(
  parameter int LIMIT = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int W = (LIMIT < 2) ? 1 : $clog2(LIMIT);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = 1'b1;
    cnt_d  = cnt_q;
    if (!run) begin
      cnt_d = '0;
    end else if (cnt_q != LAST) begin
      cnt_d = cnt_q + W'(1);
    end else begin
      cnt_en = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign done = run && (cnt_q == LAST);

  // R2 / R6: the count never passes its terminal value
  a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  // R4: a stopped timer restarts from zero
  a_r4_cnt_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0));
endmodule

// File: rtl/pdc_pwr_fsm.sv
module pdc_pwr_fsm
  import pdc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       shdn_n,
  input  logic       force_on,
  input  logic       any_act,
  input  logic       idle_done,
  input  logic       settle_done,
  output pwr_state_t state_q,
  output logic       idle_run,
  output logic       settle_run
);
  pwr_state_t state_d;

  always_comb begin
    state_d = state_q;
    if (!shdn_n) begin
      state_d = PS_OFF;
    end else begin
      unique case (state_q)
        PS_OFF:  if (force_on || any_act) state_d = PS_WAKE;
        PS_WAKE: if (settle_done) state_d = PS_ON;
        PS_ON:   if (!force_on && !any_act) state_d = PS_IDLE;
        PS_IDLE: begin
          if (force_on || any_act) state_d = PS_ON;
          else if (idle_done)      state_d = PS_OFF;
        end
        default: state_d = PS_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PS_OFF;
    else        state_q <= state_d;
  end

  assign settle_run = (state_q == PS_WAKE);
  assign idle_run   = (state_q == PS_IDLE) && !any_act && !force_on;

  // R6: full-on is only reached through settling or from the countdown
  a_r6_on_not_from_off: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_ON) |-> ($past(state_q) != PS_OFF));
  // R2: leaving the countdown for off needs a shutdown or an expired delay
  a_r2_off_reason: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_OFF && $past(state_q) == PS_IDLE)
      |-> ($past(!shdn_n) || $past(idle_done)));
  // R3: override holds the full-on state
  a_r3_forced_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_ON && shdn_n && force_on) |=> (state_q == PS_ON));
  // R4: activity during the countdown returns to full-on
  a_r4_act_back: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_IDLE && shdn_n && any_act) |=> (state_q == PS_ON));
endmodule

// File: rtl/rx_idle_pwrdn.sv
module rx_idle_pwrdn
  import pdc_pkg::*;
#(
  parameter int NUM_CH        = 5,
  parameter int IDLE_CYCLES   = 2000,
  parameter int SETTLE_CYCLES = 20000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] act_raw,
  input  logic              shdn_n,
  input  logic              force_on,
  input  logic              rx_oe_n,
  output logic              status,
  output logic              drv_en,
  output logic              pump_en,
  output logic [NUM_CH-1:0] rx_out_en,
  output logic              mon_en
);
  logic [NUM_CH-1:0] act_s;
  logic              any_act;
  logic              idle_run;
  logic              idle_done;
  logic              settle_run;
  logic              settle_done;
  pwr_state_t        state_q;
  logic              status_q;
  logic              mon_q;

  pdc_act_sync #(.NUM_CH(NUM_CH)) u_sync (
    .clk(clk), .rst_n(rst_n), .act_raw(act_raw), .act_s(act_s)
  );

  assign any_act = |act_s;

  pdc_tick_timer #(.LIMIT(IDLE_CYCLES)) u_idle_tmr (
    .clk(clk), .rst_n(rst_n), .run(idle_run), .done(idle_done)
  );

  pdc_tick_timer #(.LIMIT(SETTLE_CYCLES)) u_settle_tmr (
    .clk(clk), .rst_n(rst_n), .run(settle_run), .done(settle_done)
  );

  pdc_pwr_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .shdn_n(shdn_n), .force_on(force_on),
    .any_act(any_act), .idle_done(idle_done), .settle_done(settle_done),
    .state_q(state_q), .idle_run(idle_run), .settle_run(settle_run)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= 1'b0;
      mon_q    <= 1'b0;
    end else begin
      status_q <= shdn_n && any_act;
      mon_q    <= 1'b1;
    end
  end

  assign status    = status_q;
  assign mon_en    = mon_q;
  assign pump_en   = shdn_n && (state_q != PS_OFF);
  assign drv_en    = shdn_n && ((state_q == PS_ON) || (state_q == PS_IDLE));
  assign rx_out_en = {NUM_CH{~rx_oe_n}};

  // R1: shutdown removes driver and supply enables at once
  a_r1_shdn_off: assert property (@(posedge clk) disable iff (!rst_n)
    !shdn_n |-> (!drv_en && !pump_en));
  // R5: status can only be high after a cycle with shutdown released
  a_r5_status_pin: assert property (@(posedge clk) disable iff (!rst_n)
    status |-> $past(shdn_n));
  // R6: drivers never run without the supply generator
  a_r6_drv_needs_pump: assert property (@(posedge clk) disable iff (!rst_n)
    drv_en |-> pump_en);
endmodule

// File: tb/rx_idle_pwrdn_tb.sv
module rx_idle_pwrdn_tb;
  localparam int NCH = 3;
  localparam int IDL = 6;
  localparam int STL = 4;

  logic           clk;
  logic           rst_n;
  logic [NCH-1:0] act_raw;
  logic           shdn_n, force_on, rx_oe_n;
  logic           status, drv_en, pump_en, mon_en;
  logic [NCH-1:0] rx_out_en;
  int total = 0;
  int bad = 0;

  rx_idle_pwrdn #(.NUM_CH(NCH), .IDLE_CYCLES(IDL), .SETTLE_CYCLES(STL)) u_dut (
    .clk(clk), .rst_n(rst_n), .act_raw(act_raw), .shdn_n(shdn_n),
    .force_on(force_on), .rx_oe_n(rx_oe_n), .status(status),
    .drv_en(drv_en), .pump_en(pump_en), .rx_out_en(rx_out_en), .mon_en(mon_en)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    step(2);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL R10 watchdog got=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    act_raw = '0; shdn_n = 1'b1; force_on = 1'b0; rx_oe_n = 1'b0; rst_n = 1'b0;
    step(2);
    // R10: reset state
    chk("R10 drv", drv_en, 0); chk("R10 pump", pump_en, 0);
    chk("R10 status", status, 0); chk("R10 mon", mon_en, 0);
    rst_n = 1'b1;
    step(1);
    chk("R7 mon after reset", mon_en, 1);

    // R9 / R6 / R5: automatic wake
    act_raw = 3'b100;
    step(2); chk("R9 no wake yet", pump_en, 0);
    step(1); chk("R6 pump on", pump_en, 1); chk("R6 drv still off", drv_en, 0);
    chk("R5 status up", status, 1);
    step(STL - 1); chk("R6 drv before settle", drv_en, 0);
    step(1); chk("R6 drv after settle", drv_en, 1);

    // R2 / R5: power-down after the full delay
    act_raw = '0;
    step(2); chk("R5 status latency", status, 1);
    step(1); chk("R5 status down", status, 0); chk("R2 still on", drv_en, 1);
    step(IDL - 1); chk("R2 on at delay-1", drv_en, 1);
    step(1); chk("R2 drv off", drv_en, 0); chk("R2 pump off", pump_en, 0);

    // R4: activity pulse in the countdown restarts the delay
    act_raw = 3'b001; step(3 + STL); chk("R2 rewake", drv_en, 1);
    act_raw = '0; step(5);
    act_raw = 3'b010; step(1); act_raw = '0;
    step(3 + IDL - 1); chk("R4 delay restarted", drv_en, 1);
    step(1); chk("R4 off after fresh delay", drv_en, 0);

    // R3 / R5: override with quiet lines
    force_on = 1'b1;
    step(1); chk("R3 pump", pump_en, 1); chk("R3 drv settling", drv_en, 0);
    step(STL); chk("R3 drv on", drv_en, 1);
    step(3 * IDL); chk("R3 stays on", drv_en, 1); chk("R5 status quiet", status, 0);

    // R1: shutdown wins over override and activity
    shdn_n = 1'b0; #1;
    chk("R1 drv off now", drv_en, 0); chk("R1 pump off now", pump_en, 0);
    act_raw = 3'b111; step(10);
    chk("R1 pump held off", pump_en, 0); chk("R1 status low", status, 0);
    act_raw = '0; force_on = 1'b0; step(3);
    shdn_n = 1'b1; step(5); chk("R2 quiet stays off", pump_en, 0);

    // R6: shutdown during settling restarts the settle time
    force_on = 1'b1;
    step(1); chk("R6 waking", pump_en, 1);
    step(2); shdn_n = 1'b0; step(1); chk("R6 abort", pump_en, 0);
    shdn_n = 1'b1;
    step(1); chk("R6 rewaking", pump_en, 1);
    step(STL - 1); chk("R6 full settle again", drv_en, 0);
    step(1); chk("R6 drv after resettle", drv_en, 1);

    // R8: pins tied together
    force_on = 1'b0; shdn_n = 1'b0; act_raw = 3'b111; step(3);
    chk("R8 low off", drv_en, 0);
    act_raw = '0; step(3);
    force_on = 1'b1; shdn_n = 1'b1; step(1 + STL);
    chk("R8 high on", drv_en, 1);
    force_on = 1'b0; shdn_n = 1'b0; #1;
    chk("R8 low drv", drv_en, 0); chk("R8 low pump", pump_en, 0);
    step(1);

    // Sweep: R1 R2 R3 R5 R7 over every pin and pattern
    for (int pat = 0; pat < (1 << NCH); pat++) begin
      for (int sd = 0; sd < 2; sd++) begin
        for (int fo = 0; fo < 2; fo++) begin
          for (int oe = 0; oe < 2; oe++) begin
            act_raw = NCH'(pat); shdn_n = sd[0]; force_on = fo[0]; rx_oe_n = oe[0];
            do_reset();
            step(3 + STL + 2);
            chk("R1/R2/R3 sweep drv", drv_en, 32'(sd[0] & (fo[0] | (pat != 0))));
            chk("R1/R2/R3 sweep pump", pump_en, 32'(sd[0] & (fo[0] | (pat != 0))));
            chk("R5 sweep status", status, 32'(sd[0] & (pat != 0)));
            chk("R7 sweep rx enables", rx_out_en, 32'(oe[0] ? 0 : (1 << NCH) - 1));
            chk("R7 sweep monitor", mon_en, 1);
          end
        end
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule